// File: doc/BRIEF.md
# Frame Status Indicator Repeater

This block sits in the repeat path of a token-ring station. Each byte clock it takes one received symbol pair and sends it on to the transmit side one clock later. While it does this, it watches for the ending delimiter (T) of each frame. It then counts the control indicators (R or S) that follow the delimiter, so that each indicator's position in the frame status field is known.

Two control bits can force the fourth or the fifth indicator to S on its way through. When a forced indicator already arrived as S, the block raises a one-cycle event pulse. If a frame ends before the forced position, nothing is changed. A fragment flag given with the last pair of a broken frame turns that pair into an idle pair. When repeating is disabled, the output is an idle stream. Symbol codes are parameters.

Top module: `fs_status_repeater`

## Requirements
- R1: A valid received pair whose two symbols are neither R nor S, nor rewritten indicators, appears unchanged on `tx_pair` exactly one clock after it is presented. The first symbol in time is `rx_pair[9:5]` and the second is `rx_pair[4:0]`.
- R2: While `rep_en` is low, and after reset, `tx_pair` carries the idle pair {SYM_IDLE, SYM_IDLE}, both events stay low, and status parsing restarts from "waiting for T".
- R3: A clock with `rx_valid` low produces an idle output pair and no event, and it leaves the parser's position in the status field unchanged.
- R4: With `force_4th` set, the fourth R/S symbol after a T (the first R/S being indicator 1) is sent as SYM_S.
- R5: With `force_4th` set, a fourth indicator that arrived as SYM_S raises `ev_4th_was_s` for one clock, aligned with the output pair that carries it.
- R6: `force_5th` and `ev_5th_was_s` behave like R4 and R5 for the fifth indicator.
- R7: When the status field ends before the forced position, no symbol is changed and no event is raised.
- R8: A valid pair presented with `rx_frag` high is sent as an idle pair, raises no event, and ends any status parsing in progress.
- R9: Indicators are counted the same way whether T occupies the first or the second symbol of its pair.
- R10: The status field ends at the first symbol after T that is neither R nor S. Later R/S symbols are not counted until a new T arrives.
- R11: With both force bits clear, indicators pass unchanged and no event is raised, even when they are S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep_en | input | 1 | Repeat enable; low sends idles |
| force_4th | input | 1 | Force the fourth indicator to S |
| force_5th | input | 1 | Force the fifth indicator to S |
| rx_valid | input | 1 | Received pair is valid this clock |
| rx_frag | input | 1 | This pair ends a fragment |
| rx_pair | input | 10 | Received symbol pair, first symbol in [9:5] |
| tx_pair | output | 10 | Repeated symbol pair |
| ev_4th_was_s | output | 1 | Forced fourth indicator was already S |
| ev_5th_was_s | output | 1 | Forced fifth indicator was already S |

## Verification
The hardest cases to reach are the status-field positions that lie across pair boundaries. One case is the fifth indicator landing in the first half of a pair after T arrived in the second half. Another is a `rx_valid` gap or a fragment flag falling inside a status field. The stimulus builds symbol streams with an optional leading data symbol, which shifts the alignment of T. It varies the indicator count and the S/R mix, and it inserts invalid clocks mid-field. A long random phase then mixes T, R, S, data and control flags, and a behavioural model compares against the design on every clock.

// File: rtl/fsr_pkg.sv
// Package: shared parser state type for the frame status repeater.
// Assumes pair-wide processing: each state names the indicator positions
// expected in the (first, second) symbols of the next valid pair.
package fsr_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_T   = 3'b000,  // no status field in progress
        ST_EXP_45   = 3'b010,  // next pair holds indicators 4 and 5
        ST_EXP_AC   = 3'b011,  // next pair holds indicators 2 and 3
        ST_EXP_5    = 3'b100,  // next pair starts with indicator 5
        ST_EXP_C4   = 3'b101,  // next pair holds indicators 3 and 4
        ST_WAIT_END = 3'b110,  // past indicator 5, wait for non-R/S
        ST_EXP_EA   = 3'b111   // next pair holds indicators 1 and 2
    } fs_state_e;
endpackage

// File: rtl/fsr_sym_class.sv
// Module: classifies one symbol as indicator (R or S), S, or ending
// delimiter T. Purely combinational; codes come from parameters.
module fsr_sym_class #(
    parameter int              SYM_W = 5,
    parameter logic [SYM_W-1:0] SYM_T = 5'h1D,
    parameter logic [SYM_W-1:0] SYM_R = 5'h17,
    parameter logic [SYM_W-1:0] SYM_S = 5'h19
) (
    input  logic [SYM_W-1:0] sym,
    output logic             is_ind,
    output logic             is_s,
    output logic             is_t
);
    // Decode the symbol against the configured codes.
    always_comb begin
        is_s   = (sym == SYM_S);
        is_ind = (sym == SYM_R) || (sym == SYM_S);
        is_t   = (sym == SYM_T);
    end
endmodule

// File: rtl/fsr_parser.sv
// Module: status-field position tracker. It advances one pair per valid
// clock and flags which half of the pair must be forced to S, and which
// forced indicators already were S. It assumes the first symbol in time
// is lane 0. A fragment pair or a disable returns it to waiting for T.
module fsr_parser
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,       // rep_en & rx_valid
    input  logic clear,      // !rep_en
    input  logic frag,
    input  logic force_4th,
    input  logic force_5th,
    input  logic hi_ind,
    input  logic hi_s,
    input  logic hi_t,
    input  logic lo_ind,
    input  logic lo_s,
    input  logic lo_t,
    output logic set_s_hi,
    output logic set_s_lo,
    output logic hit_4th,
    output logic hit_5th
);
    fs_state_e state_q, state_d;
    logic      use_pair;

    // Next state when no status field continues into this pair.
    function automatic fs_state_e from_idle(input logic h_t, input logic l_ind,
                                            input logic l_t);
        if (h_t)
            return l_ind ? ST_EXP_AC : (l_t ? ST_EXP_EA : ST_WAIT_T);
        return l_t ? ST_EXP_EA : ST_WAIT_T;
    endfunction

    // Next state when both halves are indicators, per current position.
    function automatic fs_state_e advance(input fs_state_e s);
        case (s)
            ST_EXP_EA:   return ST_EXP_C4;
            ST_EXP_AC:   return ST_EXP_45;
            ST_EXP_C4:   return ST_EXP_5;
            ST_EXP_45:   return ST_WAIT_END;
            ST_EXP_5:    return ST_WAIT_END;
            ST_WAIT_END: return ST_WAIT_END;
            default:     return ST_WAIT_T;
        endcase
    endfunction

    // Position-dependent force and event decisions for the current pair.
    always_comb begin
        use_pair = step && !frag;
        set_s_hi = 1'b0;
        set_s_lo = 1'b0;
        hit_4th  = 1'b0;
        hit_5th  = 1'b0;
        if (use_pair) begin
            case (state_q)
                ST_EXP_C4: begin
                    if (hi_ind && lo_ind && force_4th) begin
                        set_s_lo = 1'b1;
                        hit_4th  = lo_s;
                    end
                end
                ST_EXP_45: begin
                    if (hi_ind && force_4th) begin
                        set_s_hi = 1'b1;
                        hit_4th  = hi_s;
                    end
                    if (hi_ind && lo_ind && force_5th) begin
                        set_s_lo = 1'b1;
                        hit_5th  = lo_s;
                    end
                end
                ST_EXP_5: begin
                    if (hi_ind && force_5th) begin
                        set_s_hi = 1'b1;
                        hit_5th  = hi_s;
                    end
                end
                default: ;
            endcase
        end
    end

    // Compute the next parser position from the pair's symbol classes.
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_WAIT_T;
        end else if (step) begin
            if (frag)
                state_d = ST_WAIT_T;
            else if (state_q == ST_WAIT_T || !hi_ind)
                state_d = from_idle(hi_t, lo_ind, lo_t);
            else if (!lo_ind)
                state_d = lo_t ? ST_EXP_EA : ST_WAIT_T;
            else
                state_d = advance(state_q);
        end
    end

    // Parser state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_T;
        else        state_q <= state_d;
    end

    // R3: an invalid clock must not move the parser.
    assert_hold_on_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(state_q));

    // R7: nothing is forced unless a force bit asks for it.
    assert_force_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_s_hi || set_s_lo) |-> (force_4th || force_5th));
endmodule

// File: rtl/fsr_out_stage.sv
// Module: one-clock output register for the repeat path. It loads the
// rewritten pair and event flags when the pair is usable, and idles otherwise.
module fsr_out_stage #(
    parameter int               PAIR_W    = 10,
    parameter logic [PAIR_W-1:0] IDLE_PAIR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic              ev4_in,
    input  logic              ev5_in,
    output logic [PAIR_W-1:0] pair_q,
    output logic              ev4_q,
    output logic              ev5_q
);
    // Register the outgoing pair and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= IDLE_PAIR;
            ev4_q  <= 1'b0;
            ev5_q  <= 1'b0;
        end else if (load) begin
            pair_q <= pair_in;
            ev4_q  <= ev4_in;
            ev5_q  <= ev5_in;
        end else begin
            pair_q <= IDLE_PAIR;
            ev4_q  <= 1'b0;
            ev5_q  <= 1'b0;
        end
    end

    // R5: an event pulse only follows a loaded pair.
    assert_ev_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev4_q || ev5_q) |-> $past(load));
endmodule

// File: rtl/fs_status_repeater.sv
// Module: frame status indicator repeater (top). It repeats received symbol
// pairs one clock later, optionally forces indicators 4/5 to S with an
// already-S event, and idles fragment tails. Lane 0 is the earlier symbol.
module fs_status_repeater #(
    parameter int               SYM_W    = 5,
    parameter logic [SYM_W-1:0] SYM_IDLE = 5'h1F,
    parameter logic [SYM_W-1:0] SYM_T    = 5'h1D,
    parameter logic [SYM_W-1:0] SYM_R    = 5'h17,
    parameter logic [SYM_W-1:0] SYM_S    = 5'h19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rep_en,
    input  logic                 force_4th,
    input  logic                 force_5th,
    input  logic                 rx_valid,
    input  logic                 rx_frag,
    input  logic [2*SYM_W-1:0]   rx_pair,
    output logic [2*SYM_W-1:0]   tx_pair,
    output logic                 ev_4th_was_s,
    output logic                 ev_5th_was_s
);
    localparam int LANES  = 2;
    localparam int PAIR_W = LANES * SYM_W;
    localparam logic [PAIR_W-1:0] IDLE_PAIR = {LANES{SYM_IDLE}};

    logic [LANES-1:0]  is_ind, is_s, is_t, set_s;
    logic [PAIR_W-1:0] mod_pair;
    logic              step, load, hit4, hit5;

    // Qualify the incoming pair.
    always_comb begin
        step = rep_en && rx_valid;
        load = step && !rx_frag;
    end

    // Per-lane classification and S substitution.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int MSB = PAIR_W - 1 - g * SYM_W;
        fsr_sym_class #(.SYM_W(SYM_W), .SYM_T(SYM_T), .SYM_R(SYM_R), .SYM_S(SYM_S))
            u_class (
                .sym    (rx_pair[MSB -: SYM_W]),
                .is_ind (is_ind[g]),
                .is_s   (is_s[g]),
                .is_t   (is_t[g])
            );
        assign mod_pair[MSB -: SYM_W] = set_s[g] ? SYM_S : rx_pair[MSB -: SYM_W];
    end

    fsr_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clear     (!rep_en),
        .frag      (rx_frag),
        .force_4th (force_4th),
        .force_5th (force_5th),
        .hi_ind    (is_ind[0]),
        .hi_s      (is_s[0]),
        .hi_t      (is_t[0]),
        .lo_ind    (is_ind[1]),
        .lo_s      (is_s[1]),
        .lo_t      (is_t[1]),
        .set_s_hi  (set_s[0]),
        .set_s_lo  (set_s[1]),
        .hit_4th   (hit4),
        .hit_5th   (hit5)
    );

    fsr_out_stage #(.PAIR_W(PAIR_W), .IDLE_PAIR(IDLE_PAIR)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .pair_in (mod_pair),
        .ev4_in  (hit4),
        .ev5_in  (hit5),
        .pair_q  (tx_pair),
        .ev4_q   (ev_4th_was_s),
        .ev5_q   (ev_5th_was_s)
    );

    // R1: non-indicator pairs pass unchanged one clock later.
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !is_ind[0] && !is_ind[1]) |=> (tx_pair == $past(rx_pair)));

    // R2: disabled repeat path emits idles without events.
    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_en |=> (tx_pair == IDLE_PAIR && !ev_4th_was_s && !ev_5th_was_s));

    // R8: a fragment tail becomes an idle pair.
    assert_frag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rx_frag) |=> (tx_pair == IDLE_PAIR));

    // R5: fourth-indicator event requires the force bit and a usable pair.
    assert_ev4_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_4th_was_s |-> $past(force_4th && load));

    // R6: fifth-indicator event requires the force bit and a usable pair.
    assert_ev5_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_5th_was_s |-> $past(force_5th && load));
endmodule

// File: tb/fs_status_repeater_test.sv
// Bench: serial per-symbol reference model (status flag + indicator count)
// compared against the design on every clock.
module fs_status_repeater_test;
    localparam logic [4:0] S_I = 5'h1F, S_T = 5'h1D, S_R = 5'h17, S_S = 5'h19;
    localparam logic [4:0] S_J = 5'h18, S_K = 5'h11;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rep_en = 1'b0, force_4th = 1'b0, force_5th = 1'b0;
    logic       rx_valid = 1'b0, rx_frag = 1'b0;
    logic [9:0] rx_pair = {S_I, S_I};
    logic [9:0] tx_pair;
    logic       ev_4th_was_s, ev_5th_was_s;

    integer n_checks = 0, n_fail = 0;
    string  cur_req = "R2";

    bit         m_in  = 1'b0;
    int         m_cnt = 0;
    logic [9:0] exp_tx = {S_I, S_I};
    logic       exp4 = 1'b0, exp5 = 1'b0;
    logic [4:0] symq[$];

    fs_status_repeater uut (
        .clk(clk), .rst_n(rst_n), .rep_en(rep_en), .force_4th(force_4th),
        .force_5th(force_5th), .rx_valid(rx_valid), .rx_frag(rx_frag),
        .rx_pair(rx_pair), .tx_pair(tx_pair), .ev_4th_was_s(ev_4th_was_s),
        .ev_5th_was_s(ev_5th_was_s)
    );

    always #4 clk = ~clk;

    // Reference model: expected output after the next clock edge.
    task automatic model_step();
        logic [4:0] s;
        exp_tx = {S_I, S_I}; exp4 = 1'b0; exp5 = 1'b0;
        if (!rst_n || !rep_en) begin
            m_in = 1'b0;
        end else if (rx_valid && rx_frag) begin
            m_in = 1'b0;
        end else if (rx_valid) begin
            for (int i = 0; i < 2; i++) begin
                s = (i == 0) ? rx_pair[9:5] : rx_pair[4:0];
                if (m_in && (s == S_R || s == S_S)) begin
                    m_cnt++;
                    if (m_cnt == 4 && force_4th) begin
                        if (s == S_S) exp4 = 1'b1;
                        s = S_S;
                    end
                    if (m_cnt == 5 && force_5th) begin
                        if (s == S_S) exp5 = 1'b1;
                        s = S_S;
                    end
                end else begin
                    m_in = (s == S_T);
                    m_cnt = 0;
                end
                if (i == 0) exp_tx[9:5] = s; else exp_tx[4:0] = s;
            end
        end
    endtask

    task automatic check();
        n_checks++;
        if (tx_pair !== exp_tx || ev_4th_was_s !== exp4 || ev_5th_was_s !== exp5) begin
            n_fail++;
            $display("FAIL %s: tx=%h ev4=%b ev5=%b expected tx=%h ev4=%b ev5=%b",
                     cur_req, tx_pair, ev_4th_was_s, ev_5th_was_s, exp_tx, exp4, exp5);
        end
    endtask

    task automatic drive(input logic [9:0] p, input logic v, input logic fr);
        rx_pair = p; rx_valid = v; rx_frag = fr;
        model_step();
        @(negedge clk);
        check();
    endtask

    // Send queued symbols as pairs, padding with idle; frag marks last pair.
    task automatic send_q(input logic frag_last);
        logic [4:0] a, b;
        while (symq.size() > 0) begin
            a = symq.pop_front();
            b = (symq.size() > 0) ? symq.pop_front() : S_I;
            drive({a, b}, 1'b1, frag_last && symq.size() == 0);
        end
    endtask

    // Frame: optional leading data (alignment), T, then listed indicators.
    task automatic frame(input bit shift, input logic [4:0] inds[$]);
        symq.push_back(S_J); symq.push_back(S_K);
        symq.push_back(5'h3); symq.push_back(5'hA);
        if (shift) symq.push_back(5'h5);
        symq.push_back(S_T);
        foreach (inds[k]) symq.push_back(inds[k]);
        symq.push_back(S_I); symq.push_back(S_I);
        send_q(1'b0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R2: reset state is idle with no events.
        cur_req = "R2";
        for (int i = 0; i < 3; i++) drive({S_T, S_R}, 1'b1, 1'b0);
        rst_n = 1'b1;
        drive({5'h1, 5'h2}, 1'b1, 1'b0);
        rep_en = 1'b1;

        cur_req = "R1";
        for (int i = 0; i < 16; i++) drive({5'(i), 5'(15 - i)}, 1'b1, 1'b0);
        drive({S_J, S_K}, 1'b1, 1'b0);

        for (int sh = 0; sh < 2; sh++) begin
            force_4th = 1'b1; force_5th = 1'b0;
            cur_req = "R4"; frame(sh[0], '{S_R, S_R, S_R, S_R, S_R, S_R});
            cur_req = "R5"; frame(sh[0], '{S_R, S_S, S_R, S_S, S_R});
            force_4th = 1'b0; force_5th = 1'b1;
            cur_req = "R6"; frame(sh[0], '{S_R, S_R, S_R, S_R, S_R});
            cur_req = "R6"; frame(sh[0], '{S_S, S_R, S_R, S_R, S_S, S_R});
            force_4th = 1'b1;
            cur_req = "R9"; frame(sh[0], '{S_S, S_S, S_R, S_S, S_S});
            cur_req = "R7"; frame(sh[0], '{S_R, S_S, S_R});
            cur_req = "R7"; frame(sh[0], '{S_R, S_R, S_R, S_S});
            cur_req = "R10"; frame(sh[0], '{S_R, S_R, 5'h6, S_S, S_S, S_S, S_S});
            force_4th = 1'b0; force_5th = 1'b0;
            cur_req = "R11"; frame(sh[0], '{S_S, S_S, S_S, S_S, S_S, S_S});
        end

        // R3: invalid gaps inside the status field.
        cur_req = "R3"; force_4th = 1'b1; force_5th = 1'b1;
        drive({5'h2, S_T}, 1'b1, 1'b0);
        drive({S_R, S_R}, 1'b1, 1'b0);
        drive({S_R, S_R}, 1'b0, 1'b0);
        drive({S_T, S_T}, 1'b0, 1'b0);
        drive({S_R, S_S}, 1'b1, 1'b0);
        drive({S_S, S_R}, 1'b1, 1'b0);

        // R8: fragment tail idled and parsing ended.
        cur_req = "R8";
        drive({S_T, S_R}, 1'b1, 1'b0);
        drive({S_R, S_S}, 1'b1, 1'b1);
        drive({S_S, S_S}, 1'b1, 1'b0);
        drive({S_S, S_S}, 1'b1, 1'b0);

        // R2: disabling mid-status restarts parsing.
        cur_req = "R2";
        drive({S_T, S_R}, 1'b1, 1'b0);
        rep_en = 1'b0;
        drive({S_R, S_R}, 1'b1, 1'b0);
        rep_en = 1'b1;
        drive({S_S, S_S}, 1'b1, 1'b0);
        drive({S_S, S_S}, 1'b1, 1'b0);

        // Random mix over all requirements.
        cur_req = "R1/R4/R5/R6/R9 random";
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a, b;
            int ra, rb;
            ra = $urandom_range(0, 9); rb = $urandom_range(0, 9);
            a = (ra < 3) ? S_R : (ra < 6) ? S_S : (ra == 6) ? S_T : (ra == 7) ? S_I : 5'($urandom_range(0, 15));
            b = (rb < 3) ? S_R : (rb < 6) ? S_S : (rb == 6) ? S_T : (rb == 7) ? S_I : 5'($urandom_range(0, 15));
            if (i % 64 == 0) begin
                force_4th = 1'($urandom); force_5th = 1'($urandom);
            end
            rep_en = ($urandom_range(0, 49) != 0);
            drive({a, b}, 1'($urandom_range(0, 9) != 0), 1'($urandom_range(0, 29) == 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule